// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block turns one active-low external interrupt pin into a request for the CPU. The pin is first brought into the clock domain by a chain of synchronizing flops. A falling edge on the synchronized value is then detected by comparing it with its value one cycle earlier. A detected edge sets a pending latch. A small control/status register holds a sensitivity mode bit and a mask bit. It also shows the pending state and accepts a write-one acknowledge.

The pending latch is cleared by the CPU's vector-fetch strobe, by a software acknowledge, or by reset. In edge mode an acknowledge clears the latch at once. In level mode the request stays pending while the pin is low. The latch clears only after both an acknowledge and the pin's return high, and these two may come in either order. The mask gates only the request line to the CPU. The pending flag always shows the latch, so software can poll the pin with the request masked. The block also presents the fixed address of the vector the CPU fetches when it takes the request.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, reg_rdata reads 0x00 and irq_req is 0.
- R2: A falling edge on pin_n sets the pending flag (reg_rdata bit 3). With the default two synchronizer stages, the flag is visible after the third rising clock edge following the pin change, and not after the second.
- R3: With the mode bit (bit 0) clear, a vec_ack pulse or a register write with bit 2 set clears the pending flag at the next clock edge, even while pin_n stays low. A pin that is held low does not set the flag again.
- R4: With the mode bit set, an acknowledge while the synchronized pin is low leaves the flag set. The flag clears on the third clock edge after pin_n returns high.
- R5: With the mode bit set, a pin that returns high without an acknowledge leaves the flag set. A later acknowledge clears it at the next edge.
- R6: The mask bit (bit 1) forces irq_req to 0 and does not change the pending flag. With the mask clear, irq_req equals the pending flag.
- R7: The acknowledge bit (bit 2) always reads 0. A write updates the mode and mask bits from wdata bits 0 and 1, whatever the value of bit 2.
- R8: If an acknowledge and a newly detected falling edge fall in the same cycle, the edge wins and the flag stays set.
- R9: Reset clears the pending flag and the mode bit even while pin_n stays low. A pin that is held low across reset does not raise a request afterwards. A falling edge still does once the pin has been seen high.
- R10: vec_addr always presents the vector address 0xFFF8. The vector occupies 0xFFF8 and 0xFFF9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| vec_ack | input | 1 | One-cycle acknowledge from the CPU's vector fetch |
| reg_wr | input | 1 | Write strobe for the control/status register |
| reg_wdata | input | 8 | Write data: bit0 mode, bit1 mask, bit2 acknowledge |
| reg_rdata | output | 8 | Read data: bit0 mode, bit1 mask, bit2 zero, bit3 pending |
| irq_req | output | 1 | Request to the CPU, pending and not masked |
| vec_addr | output | 16 | Address of the vector fetched for this request |

## Verification
A pin change reaches the pending flag after exactly three clock edges: two synchronizer flops, then the latch. The bench therefore checks the flag after two edges, when it must still be unchanged, and again after the third edge. Acknowledges and register writes act at the very next edge, so their effect is checked one edge after the strobe. Register read data and irq_req are combinational from state, so every check samples on the falling clock edge, half a period after the edge that produced the result. Inputs are driven on that same falling edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int REG_W    = 8;
    localparam int BIT_MODE = 0;
    localparam int BIT_MASK = 1;
    localparam int BIT_ACK  = 2;
    localparam int BIT_PEND = 3;

    typedef logic [REG_W-1:0] reg_t;

    typedef struct packed {
        logic mask;
        logic level_mode;
    } ctrl_t;

    typedef struct packed {
        logic pend;
        logic ack_seen;
    } latch_t;

    function automatic reg_t pack_status(ctrl_t c, logic pend);
        reg_t r;
        r           = '0;
        r[BIT_MODE] = c.level_mode;
        r[BIT_MASK] = c.mask;
        r[BIT_ACK]  = 1'b0;
        r[BIT_PEND] = pend;
        return r;
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic pin_s,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[LAST];
    end

    assign pin_s = chain[LAST];
    assign fall  = prev & ~chain[LAST];
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level_mode,
    input  logic pin_s,
    input  logic fall,
    input  logic ack,
    output logic pend
);
    latch_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (fall) begin
            st_d.pend     = 1'b1;
            st_d.ack_seen = 1'b0;
        end else if (ack) begin
            if (!level_mode || pin_s) begin
                st_d.pend     = 1'b0;
                st_d.ack_seen = 1'b0;
            end else begin
                st_d.ack_seen = st_q.pend;
            end
        end else if (!level_mode) begin
            st_d.ack_seen = 1'b0;
        end else if (st_q.ack_seen && pin_s) begin
            st_d.pend     = 1'b0;
            st_d.ack_seen = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  reg_t  wdata,
    input  logic  pend,
    output ctrl_t ctrl,
    output logic  sw_ack,
    output reg_t  rdata
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr) begin
            ctrl_q.level_mode <= wdata[BIT_MODE];
            ctrl_q.mask       <= wdata[BIT_MASK];
        end
    end

    assign ctrl   = ctrl_q;
    assign sw_ack = wr & wdata[BIT_ACK];
    assign rdata  = pack_status(ctrl_q, pend);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] VEC_ADDR    = 16'hFFF8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_n,
    input  logic              vec_ack,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_req,
    output logic [ADDR_W-1:0] vec_addr
);
    logic  pin_sync, fall_det, sw_ack, ack_any, pend_q, mode_w;
    ctrl_t ctrl;

    ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_n (pin_n),
        .pin_s (pin_sync),
        .fall  (fall_det)
    );

    ext_irq_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .pend  (pend_q),
        .ctrl  (ctrl),
        .sw_ack(sw_ack),
        .rdata (reg_rdata)
    );

    assign ack_any = vec_ack | sw_ack;
    assign mode_w  = ctrl.level_mode;

    ext_irq_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .level_mode (mode_w),
        .pin_s      (pin_sync),
        .fall       (fall_det),
        .ack        (ack_any),
        .pend       (pend_q)
    );

    assign irq_req  = pend_q & ~ctrl.mask;
    assign vec_addr = ADDR_W'(VEC_ADDR);
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
    import ext_irq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       pend,
    input logic       mode,
    input logic       ack,
    input logic       fall,
    input logic       pin_s,
    input logic       irq_req,
    input logic [7:0] rdata
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (rdata == 8'h00 && !irq_req));

    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
        fall |=> pend);

    assert_edge_ack_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (!mode && ack && !fall) |=> !pend);

    assert_level_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (mode && pend && !pin_s && !fall) |=> pend);

    assert_mask_gates_R6: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> rdata[BIT_PEND]);

    assert_ack_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        rdata[BIT_ACK] == 1'b0);

    assert_edge_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (ack && fall) |=> pend);

    assert_reset_drops_R9: assert property (@(posedge clk)
        rst |=> (!pend && !mode));
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pend    (pend_q),
    .mode    (mode_w),
    .ack     (ack_any),
    .fall    (fall_det),
    .pin_s   (pin_sync),
    .irq_req (irq_req),
    .rdata   (reg_rdata)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        pin_n;
    logic        vec_ack;
    logic        reg_wr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        irq_req;
    logic [15:0] vec_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ext_irq_ctrl i_ext_irq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .pin_n     (pin_n),
        .vec_ack   (vec_ack),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req),
        .vec_addr  (vec_addr)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic pulse_vec;
        vec_ack = 1'b1;
        tick(1);
        vec_ack = 1'b0;
    endtask

    task automatic do_reset;
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        pin_n = 1'b1; vec_ack = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
        do_reset();
        check("R1 rdata", {8'h00, reg_rdata}, 16'h0000);
        check("R1 irq", {15'd0, irq_req}, 16'd0);
        check("R10 vec_addr", vec_addr, 16'hFFF8);
        tick(3);
    endtask

    task automatic t_edge_mode;
        pin_n = 1'b0;
        tick(2);
        check("R2 not yet", {15'd0, reg_rdata[3]}, 16'd0);
        tick(1);
        check("R2 pend", {15'd0, reg_rdata[3]}, 16'd1);
        check("R6 irq unmasked", {15'd0, irq_req}, 16'd1);
        pulse_vec();
        check("R3 vec clears", {15'd0, reg_rdata[3]}, 16'd0);
        tick(5);
        check("R3 no retrigger", {15'd0, reg_rdata[3]}, 16'd0);
        pin_n = 1'b1; tick(3);
        pin_n = 1'b0; tick(3);
        check("R2 second edge", {15'd0, reg_rdata[3]}, 16'd1);
        wr_reg(8'h04);
        check("R3 sw ack clears", {15'd0, reg_rdata[3]}, 16'd0);
        check("R7 ack reads 0", {8'h00, reg_rdata}, 16'h0000);
        pin_n = 1'b1; tick(3);
    endtask

    task automatic t_mask;
        wr_reg(8'h02);
        pin_n = 1'b0; tick(3);
        check("R6 pend masked", {8'h00, reg_rdata}, 16'h000A);
        check("R6 irq masked", {15'd0, irq_req}, 16'd0);
        wr_reg(8'h00);
        check("R6 irq unmask", {15'd0, irq_req}, 16'd1);
        wr_reg(8'h04);
        check("R6 cleared", {15'd0, irq_req}, 16'd0);
        pin_n = 1'b1; tick(3);
        wr_reg(8'h07);
        check("R7 fields", {8'h00, reg_rdata}, 16'h0003);
        wr_reg(8'h00);
    endtask

    task automatic t_level_ack_first;
        wr_reg(8'h01);
        pin_n = 1'b0; tick(3);
        check("R4 pend", {15'd0, reg_rdata[3]}, 16'd1);
        wr_reg(8'h05);
        check("R4 held after ack", {15'd0, reg_rdata[3]}, 16'd1);
        pulse_vec();
        tick(4);
        check("R4 held while low", {15'd0, reg_rdata[3]}, 16'd1);
        pin_n = 1'b1;
        tick(2);
        check("R4 not yet high", {15'd0, reg_rdata[3]}, 16'd1);
        tick(1);
        check("R4 cleared", {15'd0, reg_rdata[3]}, 16'd0);
    endtask

    task automatic t_level_pin_first;
        pin_n = 1'b0; tick(3);
        check("R5 pend", {15'd0, reg_rdata[3]}, 16'd1);
        pin_n = 1'b1; tick(5);
        check("R5 held no ack", {15'd0, reg_rdata[3]}, 16'd1);
        pulse_vec();
        check("R5 ack clears", {15'd0, reg_rdata[3]}, 16'd0);
        wr_reg(8'h00);
    endtask

    task automatic t_same_cycle;
        pin_n = 1'b0;
        tick(2);
        vec_ack = 1'b1;
        tick(1);
        vec_ack = 1'b0;
        check("R8 edge wins", {15'd0, reg_rdata[3]}, 16'd1);
        pulse_vec();
        check("R8 later ack", {15'd0, reg_rdata[3]}, 16'd0);
        pin_n = 1'b1; tick(3);
    endtask

    task automatic t_reset_low;
        wr_reg(8'h01);
        pin_n = 1'b0; tick(3);
        check("R9 pend before", {15'd0, reg_rdata[3]}, 16'd1);
        do_reset();
        check("R9 cleared", {8'h00, reg_rdata}, 16'h0000);
        tick(6);
        check("R9 low pin no req", {8'h00, reg_rdata}, 16'h0000);
        pin_n = 1'b1; tick(3);
        pin_n = 1'b0; tick(3);
        check("R9 edge after reset", {15'd0, reg_rdata[3]}, 16'd1);
    endtask

    initial begin
        rst = 1'b1; pin_n = 1'b1; vec_ack = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
        t_reset();
        t_edge_mode();
        t_mask();
        t_level_ack_first();
        t_level_pin_first();
        t_same_cycle();
        t_reset_low();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule